// File: doc/BRIEF.md
# Double-Data-Rate Pixel Bus Demultiplexer

This block sits between the resolved differential receivers of a column driver and its channel loader. Nine single-ended lanes each carry two bits in every clock period: a first field while the clock is high and a second field while it is low. The block captures the first field on the falling edge, then joins it with the second field on the following rising edge to form one 18-bit pixel word of three 6-bit colour fields.

A polarity control can invert every received data bit. That control is sampled together with the first field, so one word never mixes the two polarities. The loader supplies a load-enable signal. Words are captured only while it is high, and a valid strobe marks each captured word. While the enable is low, the last word stays on the output.

Top module: `ddr_pix_demux`

## Requirements
- R1: While rst_ni is low, pix_o is all zeros and valid_o is 0.
- R2: Lane l = 3*c + p (c = 0 blue, 1 green, 2 red; p = 0..2) feeds bits 2p and 2p+1 of colour field c. In pix_o, blue is [5:0], green is [11:6] and red is [17:12].
- R3: On every lane, the field present before the falling edge (first phase) becomes the even bit 2p. The field present before the next rising edge (second phase) becomes the odd bit 2p+1.
- R4: One complete word is produced per clock period. The two fields presented in a period appear on pix_o just after the rising edge that ends that period.
- R5: When invert_i is 1, all 18 bits of the word are the complement of the received bits. When it is 0, the bits pass unchanged.
- R6: invert_i is sampled at the falling edge, with the first field. A change of invert_i between that falling edge and the next rising edge does not affect the word.
- R7: valid_o is the value of load_en_i at the latest rising edge. It is 1 for exactly the clock periods whose words were captured.
- R8: When load_en_i is 0 at a rising edge, pix_o keeps its previous value whatever the lanes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane clock; first field sampled on its falling edge, second field on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_i | input | 9 | Resolved data lanes, two fields per clock period |
| invert_i | input | 1 | 1 inverts every data bit of the word |
| load_en_i | input | 1 | Load-enable from the channel loader |
| pix_o | output | 18 | Pixel word {red, green, blue} |
| valid_o | output | 1 | High for one cycle per captured word |

## Verification
The bench sweeps every value 0 to 63 through each colour field in turn, with the other fields zero, at both polarities. This shows that each field lands in its own position with the right bit order and does not leak into its neighbours. A walking single bit over all 18 positions tells the even/odd phase assignment apart from a swapped lane or swapped pair. A pseudo-random run then checks mixed words, late polarity flips inside a word, and enable gaps in which the lanes carry new data that must not reach the output. A reset pulse in the middle of the run checks that the block clears at once.

// File: rtl/ddr_pix_pkg.sv
package ddr_pix_pkg;

  typedef enum int unsigned {
    COL_BLUE  = 0,
    COL_GREEN = 1,
    COL_RED   = 2
  } colour_e;

  // lane index carrying pair p of colour c
  function automatic int unsigned lane_of(int unsigned c, int unsigned p, int unsigned lpc);
    return c * lpc + p;
  endfunction

  // even bit position of pair p inside the pixel word
  function automatic int unsigned even_bit_of(int unsigned c, int unsigned p, int unsigned lpc);
    return c * (2 * lpc) + 2 * p;
  endfunction

endpackage

// File: rtl/ddr_pix_fall_capture.sv
module ddr_pix_fall_capture #(
  parameter int LANES = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  input  logic             invert_i,
  output logic [LANES-1:0] first_o,
  output logic             inv_o
);

  // first field and polarity are taken together so a word never splits
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= '0;
      inv_o   <= 1'b0;
    end else begin
      first_o <= lane_i;
      inv_o   <= invert_i;
    end
  end

endmodule

// File: rtl/ddr_pix_lane_map.sv
module ddr_pix_lane_map
  import ddr_pix_pkg::*;
#(
  parameter int LANES_PER_COLOUR = 3,
  parameter int NUM_COLOURS      = 3,
  localparam int LANES = NUM_COLOURS * LANES_PER_COLOUR,
  localparam int PIX_W = 2 * LANES
) (
  input  logic [LANES-1:0] first_i,
  input  logic [LANES-1:0] second_i,
  output logic [PIX_W-1:0] word_o
);

  for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_colour
    for (genvar p = 0; p < LANES_PER_COLOUR; p++) begin : g_pair
      localparam int unsigned LN = lane_of(c, p, LANES_PER_COLOUR);
      localparam int unsigned EB = even_bit_of(c, p, LANES_PER_COLOUR);
      assign word_o[EB]   = first_i[LN];
      assign word_o[EB+1] = second_i[LN];
    end
  end

endmodule

// File: rtl/ddr_pix_out_stage.sv
module ddr_pix_out_stage #(
  parameter int PIX_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] word_i,
  input  logic             inv_i,
  input  logic             load_en_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o
);

  logic [PIX_W-1:0] word_pol;

  always_comb word_pol = word_i ^ {PIX_W{inv_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_en_i;
      if (load_en_i) pix_o <= word_pol;
    end
  end

endmodule

// File: rtl/ddr_pix_demux.sv
module ddr_pix_demux #(
  parameter int LANES_PER_COLOUR = 3,
  parameter int NUM_COLOURS      = 3,
  localparam int LANES = NUM_COLOURS * LANES_PER_COLOUR,
  localparam int PIX_W = 2 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  input  logic             invert_i,
  input  logic             load_en_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o
);

  logic [LANES-1:0] first_q;
  logic             inv_q;
  logic [PIX_W-1:0] word;

  ddr_pix_fall_capture #(.LANES(LANES)) u_fall (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_i   (lane_i),
    .invert_i (invert_i),
    .first_o  (first_q),
    .inv_o    (inv_q)
  );

  ddr_pix_lane_map #(
    .LANES_PER_COLOUR (LANES_PER_COLOUR),
    .NUM_COLOURS      (NUM_COLOURS)
  ) u_map (
    .first_i  (first_q),
    .second_i (lane_i),
    .word_o   (word)
  );

  ddr_pix_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (word),
    .inv_i     (inv_q),
    .load_en_i (load_en_i),
    .pix_o     (pix_o),
    .valid_o   (valid_o)
  );

endmodule

// File: rtl/ddr_pix_demux_chk.sv
module ddr_pix_demux_chk #(
  parameter int PIX_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_en_i,
  input logic [PIX_W-1:0] pix_o,
  input logic             valid_o
);

  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && pix_o == '0));

  assert_valid_follows_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(load_en_i));

  assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(load_en_i)) |-> $stable(pix_o));

  assert_word_known_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !$isunknown(pix_o));

endmodule

bind ddr_pix_demux ddr_pix_demux_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_en_i (load_en_i),
  .pix_o     (pix_o),
  .valid_o   (valid_o)
);

// File: tb/ddr_pix_demux_test.sv
`timescale 1ns/1ps
module ddr_pix_demux_test;

  localparam int LPC = 3;
  localparam int NC  = 3;
  localparam int LN  = NC * LPC;
  localparam int PW  = 2 * LN;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [LN-1:0] lane_i = '0;
  logic          invert_i = 1'b0;
  logic          load_en_i = 1'b0;
  logic [PW-1:0] pix_o;
  logic          valid_o;

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] exp_pix = '0;
  logic          exp_valid = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;

  always #5 clk_i = ~clk_i;

  ddr_pix_demux #(.LANES_PER_COLOUR(LPC), .NUM_COLOURS(NC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_i(lane_i), .invert_i(invert_i),
    .load_en_i(load_en_i), .pix_o(pix_o), .valid_o(valid_o)
  );

  task automatic check(input string tag);
    checks++;
    if (pix_o !== exp_pix || valid_o !== exp_valid) begin
      fails++;
      $display("FAIL %s: pix=%h exp=%h valid=%b exp=%b", tag, pix_o, exp_pix, valid_o, exp_valid);
    end
  endtask

  // R2/R3 lane encoding: lane 3c+p carries bit 6c+2p first, 6c+2p+1 second
  function automatic logic [LN-1:0] lanes_of(input logic [PW-1:0] w, input bit odd);
    logic [LN-1:0] l;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < LPC; p++)
        l[c*LPC+p] = w[c*2*LPC + 2*p + (odd ? 1 : 0)];
    return l;
  endfunction

  // called just after a rising edge; drives one period then checks after the next rising edge
  task automatic send(input logic [PW-1:0] w, input bit inv, input bit en,
                      input bit late_flip, input string tag);
    lane_i    = lanes_of(w, 1'b0);
    invert_i  = inv;
    load_en_i = en;
    @(negedge clk_i);
    #1;
    lane_i = lanes_of(w, 1'b1);
    if (late_flip) invert_i = ~inv;
    @(posedge clk_i);
    #1;
    exp_valid = en;
    if (en) exp_pix = inv ? ~w : w;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: pix=%h exp=%h", pix_o, exp_pix);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12;
    check("R1 reset");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    check("R1 after release");

    // R2 R3 R5: each colour field through all 64 values, both polarities
    for (int c = 0; c < NC; c++)
      for (int v = 0; v < 64; v++)
        for (int inv = 0; inv < 2; inv++)
          send(PW'(v) << (6*c), inv[0], 1'b1, 1'b0, "R2 R5 field sweep");

    // R3: walking one over all positions
    for (int b = 0; b < PW; b++) send(PW'(1) << b, 1'b0, 1'b1, 1'b0, "R3 walking bit");

    // R4: back-to-back alternating words
    send(18'h15555, 1'b0, 1'b1, 1'b0, "R4 word a");
    send(18'h2AAAA, 1'b0, 1'b1, 1'b0, "R4 word b");

    // R6: polarity flips after the falling edge
    send(18'h0F0F0, 1'b0, 1'b1, 1'b1, "R6 late flip to 1");
    send(18'h0F0F0, 1'b1, 1'b1, 1'b1, "R6 late flip to 0");

    // R7 R8: disabled periods carry new data that must not appear
    send(18'h12345, 1'b0, 1'b1, 1'b0, "R7 enabled");
    send(18'h3FFFF, 1'b1, 1'b0, 1'b0, "R8 idle hold");
    send(18'h00001, 1'b0, 1'b0, 1'b0, "R8 idle hold 2");
    send(18'h2F00D, 1'b0, 1'b1, 1'b0, "R7 re-enable");

    // mixed random run
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send({lfsr[1:0], lfsr}, lfsr[3], lfsr[5] | lfsr[6], lfsr[8], "R4 R6 R7 R8 random");
    end

    // R1: reset in mid-run
    #2;
    rst_ni = 1'b0;
    #1;
    exp_pix = '0; exp_valid = 1'b0;
    check("R1 mid-run reset");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    send(18'h3C3C3, 1'b0, 1'b1, 1'b0, "R1 recover");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule